// File: doc/BRIEF.md
# Magic Packet Wake-Up Detector

This block watches a received Ethernet frame presented as a byte stream and decides whether the frame is a wake-up frame for a programmed 48-bit station address. Such a frame carries, somewhere after its destination field, a synchronization run of six 0xFF bytes followed by the station address repeated sixteen times back to back. The destination field is checked as well. By default it must equal the station address. Two independent register bits can widen it so that any destination is accepted, and this widening never changes the payload rule.

A small host register holds the configuration bits and a write-one-to-clear interrupt flag. The detector is armed only while the mode bit is set and either the host enable bit or the external power-good input is high. The verdict is taken on the last byte of a frame that the receiver marks good. The flag then raises an interrupt, gated by its own enable bit and by a global interrupt enable input. Hard reset and soft reset clear every register bit. A stop command clears only the flag.

Top module: `magic_wake_detector`

## Requirements
- R1: After hard reset, `reg_rdata` reads 0, `irq` is 0 and `mode_active` is 0.
- R2: With both accept-any bits at 0, a frame sets the flag only if its first six bytes equal the station address, sent least significant byte (`station_addr[7:0]`) first.
- R3: With register bit 0 or register bit 1 at 1, the destination bytes are not checked, so unicast, multicast or broadcast frames qualify on the payload alone.
- R4: The payload qualifies only if a run of at least six 0xFF bytes is followed at once by sixteen back-to-back copies of the station address, least significant byte first. Fifteen copies, or a run of five 0xFF bytes, does not qualify.
- R5: A byte that breaks an address repetition restarts the search, and if that byte is 0xFF it counts as the first byte of a new synchronization run.
- R6: `mode_active` is 1 exactly when register bit 4 (mode) is 1 and either `power_good` is 1 or register bit 3 (host enable) is 1. A qualifying frame sets the flag only while `mode_active` is 1.
- R7: The flag (register bit 5) is set at the end-of-frame byte and only when `rx_good` is 1 on that byte. It is readable in the cycle after that byte.
- R8: `irq` is 1 exactly when the flag, register bit 2 (interrupt enable) and `glob_int_en` are all 1.
- R9: A register write with `reg_wdata[5]`=1 clears the flag, and with `reg_wdata[5]`=0 it leaves the flag unchanged. Bits 4:0 take the written value.
- R10: A `stop_cmd` pulse clears the flag and leaves bits 4:0 unchanged.
- R11: A `soft_rst` pulse clears all six register bits.
- R12: The register layout is bit 0 accept-any (primary), bit 1 accept-any (extended), bit 2 interrupt enable, bit 3 host enable, bit 4 mode, bit 5 flag. `reg_rdata` reflects the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| stop_cmd | input | 1 | Stop command pulse, clears the flag |
| station_addr | input | 48 | Programmed station address |
| power_good | input | 1 | External power-good, can arm the detector |
| glob_int_en | input | 1 | Global interrupt enable |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_valid | input | 1 | rx_byte holds a frame byte |
| rx_eof | input | 1 | Last byte of a frame (with rx_valid) |
| rx_good | input | 1 | Frame good, sampled with rx_eof |
| rx_byte | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data |
| irq | output | 1 | Interrupt output |
| mode_active | output | 1 | Detector armed |

## Verification
The hardest case to reach is a repetition that is broken by a 0xFF byte that is itself the start of a valid synchronization run. If that byte were dropped instead of re-examined, the frame would be missed. The bench builds a frame with a sync run, three full copies, a partial copy, and then a fresh run and sixteen copies that begin exactly at the breaking byte. Neighbouring frames probe the boundaries: fifteen copies, a five-byte run and an overlong run.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
    localparam int REG_W    = 6;
    localparam int BIT_ACC  = 0;
    localparam int BIT_ACCX = 1;
    localparam int BIT_IEN  = 2;
    localparam int BIT_HEN  = 3;
    localparam int BIT_MODE = 4;
    localparam int BIT_FLAG = 5;
    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    typedef struct packed {
        logic mode;
        logic hen;
        logic ien;
        logic accx;
        logic acc;
    } mwd_cfg_t;
endpackage

// File: rtl/mwd_scan.sv
module mwd_scan #(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int REPEATS    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic                    accept_any,
    input  logic                    rx_sof,
    input  logic                    rx_valid,
    input  logic                    rx_eof,
    input  logic                    rx_good,
    input  logic [7:0]              rx_byte,
    output logic                    hit
);
    import mwd_pkg::*;

    localparam int IW = $clog2(ADDR_BYTES + 1);
    localparam int PW = $clog2(ADDR_BYTES);
    localparam int SW = $clog2(SYNC_LEN + 1);
    localparam int RW = $clog2(REPEATS + 1);
    localparam logic [IW-1:0] IDX_END  = IW'(ADDR_BYTES);
    localparam logic [PW-1:0] POS_LAST = PW'(ADDR_BYTES - 1);
    localparam logic [SW-1:0] SYNC_END = SW'(SYNC_LEN);
    localparam logic [RW-1:0] REP_LAST = RW'(REPEATS - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          dest_ok;
        logic [SW-1:0] ff_cnt;
        logic [PW-1:0] pos;
        logic [RW-1:0] reps;
        logic          found;
    } scan_t;

    localparam scan_t FRAME_INIT = '{idx: '0, dest_ok: 1'b1, ff_cnt: '0,
                                     pos: '0, reps: '0, found: 1'b0};

    logic [7:0] abyte [ADDR_BYTES];
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
        assign abyte[g] = station_addr[8*g +: 8];
    end

    scan_t st_q, st_d, cur;
    logic  [7:0] exp_byte;
    logic  is_sync;

    always_comb begin
        cur      = rx_sof ? FRAME_INIT : st_q;
        st_d     = st_q;
        exp_byte = abyte[cur.pos];
        is_sync  = (rx_byte == SYNC_BYTE);
        if (rx_valid) begin
            st_d = cur;
            if (cur.idx < IDX_END) begin
                if (rx_byte != abyte[cur.idx]) st_d.dest_ok = 1'b0;
                st_d.idx = cur.idx + 1'b1;
            end else if (!cur.found) begin
                if (cur.ff_cnt < SYNC_END) begin
                    st_d.ff_cnt = is_sync ? cur.ff_cnt + 1'b1 : '0;
                end else if (rx_byte == exp_byte) begin
                    if (cur.pos == POS_LAST) begin
                        st_d.pos  = '0;
                        st_d.reps = cur.reps + 1'b1;
                        if (cur.reps == REP_LAST) st_d.found = 1'b1;
                    end else begin
                        st_d.pos = cur.pos + 1'b1;
                    end
                end else if (is_sync && cur.pos == '0 && cur.reps == '0) begin
                    st_d.ff_cnt = cur.ff_cnt;
                end else begin
                    st_d.pos    = '0;
                    st_d.reps   = '0;
                    st_d.ff_cnt = is_sync ? SW'(1) : '0;
                end
            end
        end
        if (soft_rst) st_d = FRAME_INIT;
        hit = rx_valid && rx_eof && rx_good && st_d.found &&
              (accept_any || st_d.dest_ok) && (st_d.idx == IDX_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FRAME_INIT;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mwd_regs.sv
module mwd_regs (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      stop_cmd,
    input  logic                      reg_wr,
    input  logic [mwd_pkg::REG_W-1:0] reg_wdata,
    input  logic                      hit,
    input  logic                      power_good,
    input  logic                      glob_int_en,
    output logic [mwd_pkg::REG_W-1:0] reg_rdata,
    output logic                      accept_any,
    output logic                      mode_active,
    output logic                      irq
);
    import mwd_pkg::*;

    typedef struct packed {
        mwd_cfg_t cfg;
        logic     flag;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        mode_active = r_q.cfg.mode && (power_good || r_q.cfg.hen);
        if (reg_wr) begin
            r_d.cfg.acc  = reg_wdata[BIT_ACC];
            r_d.cfg.accx = reg_wdata[BIT_ACCX];
            r_d.cfg.ien  = reg_wdata[BIT_IEN];
            r_d.cfg.hen  = reg_wdata[BIT_HEN];
            r_d.cfg.mode = reg_wdata[BIT_MODE];
            if (reg_wdata[BIT_FLAG]) r_d.flag = 1'b0;
        end
        if (hit && mode_active) r_d.flag = 1'b1;
        if (stop_cmd)           r_d.flag = 1'b0;
        if (soft_rst)           r_d = '0;

        reg_rdata           = '0;
        reg_rdata[BIT_ACC]  = r_q.cfg.acc;
        reg_rdata[BIT_ACCX] = r_q.cfg.accx;
        reg_rdata[BIT_IEN]  = r_q.cfg.ien;
        reg_rdata[BIT_HEN]  = r_q.cfg.hen;
        reg_rdata[BIT_MODE] = r_q.cfg.mode;
        reg_rdata[BIT_FLAG] = r_q.flag;
        accept_any          = r_q.cfg.acc || r_q.cfg.accx;
        irq                 = r_q.flag && r_q.cfg.ien && glob_int_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/magic_wake_detector.sv
module magic_wake_detector #(
    parameter int ADDR_BYTES = 6,
    parameter int SYNC_LEN   = 6,
    parameter int REPEATS    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      stop_cmd,
    input  logic [ADDR_BYTES*8-1:0]   station_addr,
    input  logic                      power_good,
    input  logic                      glob_int_en,
    input  logic                      rx_sof,
    input  logic                      rx_valid,
    input  logic                      rx_eof,
    input  logic                      rx_good,
    input  logic [7:0]                rx_byte,
    input  logic                      reg_wr,
    input  logic [mwd_pkg::REG_W-1:0] reg_wdata,
    output logic [mwd_pkg::REG_W-1:0] reg_rdata,
    output logic                      irq,
    output logic                      mode_active
);
    logic accept_any;
    logic hit;

    mwd_scan #(
        .ADDR_BYTES(ADDR_BYTES),
        .SYNC_LEN  (SYNC_LEN),
        .REPEATS   (REPEATS)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .station_addr(station_addr),
        .accept_any  (accept_any),
        .rx_sof      (rx_sof),
        .rx_valid    (rx_valid),
        .rx_eof      (rx_eof),
        .rx_good     (rx_good),
        .rx_byte     (rx_byte),
        .hit         (hit)
    );

    mwd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .stop_cmd   (stop_cmd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .hit        (hit),
        .power_good (power_good),
        .glob_int_en(glob_int_en),
        .reg_rdata  (reg_rdata),
        .accept_any (accept_any),
        .mode_active(mode_active),
        .irq        (irq)
    );
endmodule

// File: rtl/mwd_checker.sv
module mwd_checker (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      soft_rst,
    input logic                      stop_cmd,
    input logic                      power_good,
    input logic                      glob_int_en,
    input logic                      rx_valid,
    input logic                      rx_eof,
    input logic                      rx_good,
    input logic                      reg_wr,
    input logic [mwd_pkg::REG_W-1:0] reg_wdata,
    input logic [mwd_pkg::REG_W-1:0] reg_rdata,
    input logic                      irq,
    input logic                      mode_active
);
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (glob_int_en && reg_rdata[2] && reg_rdata[5]));

    a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mode_active |-> (reg_rdata[4] && (power_good || reg_rdata[3])));

    a_r7_flag_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[5]) |-> $past(rx_valid && rx_eof && rx_good && mode_active));

    a_r9_write_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[5] && reg_rdata[5] && !stop_cmd && !soft_rst)
        |=> reg_rdata[5]);

    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> !reg_rdata[5]);

    a_r10_stop_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !reg_wr && !soft_rst) |=> $stable(reg_rdata[4:0]));

    a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reg_rdata == '0));
endmodule

bind magic_wake_detector mwd_checker u_chk (.*);

// File: tb/tb_magic_wake_detector.sv
module tb_magic_wake_detector;
    localparam logic [47:0] STA = 48'h5A_43_21_0B_9C_E7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, stop_cmd = 1'b0;
    logic        power_good = 1'b0, glob_int_en = 1'b1;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_good = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_wdata = 6'h0;
    logic [5:0]  reg_rdata;
    logic        irq, mode_active;

    int total = 0;
    int bad = 0;
    logic [5:0] cfg = 6'h0;
    logic [7:0] fb[$];
    logic       exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    magic_wake_detector dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
        .station_addr(STA), .power_good(power_good), .glob_int_en(glob_int_en),
        .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_eof(rx_eof), .rx_good(rx_good),
        .rx_byte(rx_byte), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mode_active(mode_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops an expected flag value one step after each end-of-frame byte
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {31'b0, reg_rdata[5]}, {31'b0, e});
        end
    end

    task automatic reg_write(input logic [5:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        cfg = {1'b0, v[4:0]};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic clr_flag();
        reg_write(cfg | 6'h20);
    endtask

    task automatic fb_addr(input logic [47:0] a);
        for (int i = 0; i < 6; i++) fb.push_back(a[8*i +: 8]);
    endtask

    task automatic fb_fill(input int n, input logic [7:0] v);
        for (int i = 0; i < n; i++) fb.push_back(v);
    endtask

    task automatic fb_reps(input int n);
        for (int i = 0; i < n; i++) fb_addr(STA);
    endtask

    task automatic fb_std_head(input logic [47:0] dest);
        fb.delete();
        fb_addr(dest);
        fb_fill(8, 8'h11);
    endtask

    // driver: sends fb and pushes the expected flag into the scoreboard
    task automatic send_frame(input logic good, input logic exp, input string tag);
        fb_fill(4, 8'h22);
        for (int i = 0; i < fb.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = fb[i];
            rx_sof   = (i == 0);
            rx_eof   = (i == fb.size() - 1);
            rx_good  = (i == fb.size() - 1) ? good : 1'b0;
            if (i == fb.size() - 1) begin
                exp_q.push_back(exp);
                tag_q.push_back(tag);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
        @(negedge clk);
    endtask

    task automatic good_magic(input logic [47:0] dest, input logic exp, input string tag);
        fb_std_head(dest);
        fb_fill(6, 8'hFF);
        fb_reps(16);
        send_frame(1'b1, exp, tag);
    endtask

    initial begin
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata", {26'b0, reg_rdata}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode_active", {31'b0, mode_active}, 0);

        reg_write(6'h1C);
        chk("R12 layout", {26'b0, reg_rdata}, 32'h1C);
        chk("R6 armed by host", {31'b0, mode_active}, 1);

        good_magic(STA, 1'b1, "R2 unicast match");
        chk("R8 irq on", {31'b0, irq}, 1);
        glob_int_en = 1'b0; #1;
        chk("R8 global gate", {31'b0, irq}, 0);
        glob_int_en = 1'b1;
        reg_write(6'h18);
        chk("R8 enable gate", {31'b0, irq}, 0);
        chk("R9 write0 keeps", {31'b0, reg_rdata[5]}, 1);
        reg_write(6'h3C);
        chk("R9 write1 clears", {31'b0, reg_rdata[5]}, 0);
        chk("R9 cfg written", {27'b0, reg_rdata[4:0]}, 32'h1C);

        good_magic(48'hFFFF_FFFF_FFFF, 1'b0, "R2 broadcast rejected");
        clr_flag();
        good_magic(48'h5A_43_21_0B_9C_E6, 1'b0, "R2 off-by-one dest");
        clr_flag();

        reg_write(6'h1E);
        good_magic(48'hFFFF_FFFF_FFFF, 1'b1, "R3 ext bit broadcast");
        clr_flag();
        reg_write(6'h1D);
        good_magic(48'h00_00_5E_00_00_01, 1'b1, "R3 primary bit multicast");
        clr_flag();
        reg_write(6'h1C);

        fb_std_head(STA); fb_fill(6, 8'hFF); fb_reps(15);
        send_frame(1'b1, 1'b0, "R4 fifteen copies");
        clr_flag();
        fb_std_head(STA); fb_fill(5, 8'hFF); fb_reps(16);
        send_frame(1'b1, 1'b0, "R4 short sync");
        clr_flag();
        fb_std_head(STA); fb_fill(9, 8'hFF); fb_reps(16);
        send_frame(1'b1, 1'b1, "R4 long sync");
        clr_flag();

        fb_std_head(STA); fb_fill(6, 8'hFF); fb_reps(3);
        fb.push_back(STA[7:0]); fb.push_back(STA[15:8]);
        fb_fill(6, 8'hFF); fb_reps(16);
        send_frame(1'b1, 1'b1, "R5 breaking FF reused");
        clr_flag();
        fb_std_head(STA); fb_fill(6, 8'hFF); fb_reps(3);
        fb.push_back(8'h00); fb_fill(5, 8'hFF); fb_reps(16);
        send_frame(1'b1, 1'b0, "R5 break then short sync");
        clr_flag();

        fb_std_head(STA); fb_fill(6, 8'hFF); fb_reps(16);
        send_frame(1'b0, 1'b0, "R7 bad frame");
        clr_flag();

        reg_write(6'h14);
        chk("R6 disarmed", {31'b0, mode_active}, 0);
        good_magic(STA, 1'b0, "R6 no flag disarmed");
        power_good = 1'b1; #1;
        chk("R6 armed by power", {31'b0, mode_active}, 1);
        good_magic(STA, 1'b1, "R6 flag via power good");

        @(negedge clk); stop_cmd = 1'b1;
        @(negedge clk); stop_cmd = 1'b0;
        chk("R10 stop clears flag", {31'b0, reg_rdata[5]}, 0);
        chk("R10 stop keeps cfg", {27'b0, reg_rdata[4:0]}, 32'h14);

        good_magic(STA, 1'b1, "R7 flag before soft reset");
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R11 soft reset", {26'b0, reg_rdata}, 0);
        chk("R11 disarmed", {31'b0, mode_active}, 0);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule